// File: doc/BRIEF.md
# Memory-Device Boundary-Scan Test Access Port

This block is the boundary-scan test port of a synchronous memory device. A tester drives it serially through the test clock, mode select and data inputs. It runs the sixteen-state test-port controller, keeps a three-bit instruction, and places one of three data registers between the serial input and output. The three data registers are a one-bit bypass stage, a 32-bit identification word and a 71-bit boundary register.

The memory core sees three controls from this block. The first is a capture strobe that marks when the I/O ring is being sampled. The second is a force signal that puts every memory output driver into high impedance. The third is a two-bit code that names the register currently in the scan path. The pads and the array are not part of the block. The I/O ring appears only as a 71-bit parallel input, and no scan cell ever drives a pad.

Top module: `mem_jtag_tap`

## Requirements
- R1: The controller follows the standard sixteen-state test-port graph, sampling `tms` on the rising edge of `tck`. Five rising edges with `tms`=1 reach Test-Logic-Reset from any state. When `TRST_EN`=1, `trst` high at a rising edge also forces Test-Logic-Reset.
- R2: `reg_sel` decodes the latched instruction as follows. Codes 000, 010 and 100 give 2 (boundary register). Code 001 gives 1 (identification). Code 111 gives 0 (bypass).
- R3: The unassigned codes 011, 101 and 110 act as bypass (`reg_sel`=0) and leave `hiz_force` low.
- R4: `hiz_force` goes high when code 000 or 010 is latched in Update-IR. It goes low when any other code is latched, or when the controller is in Test-Logic-Reset.
- R5: For codes 000, 010 and 100, `cap_strobe` is high while the controller is in Capture-DR. `ring_in` is loaded into the boundary register and shifted out with bit 0 first.
- R6: Code 100 leaves `hiz_force` low. Data shifted in under code 100 never reaches the outputs, because every later capture reloads the register from `ring_in`.
- R7: Capture-DR under code 001 loads the identification word, which is shifted out with bit 0 first. Its fields are: bits 31:29 = 001, bits 28:24 = 01010, bits 23:18 = 000000, bits 17:12 = 100110 when `WIDE36`=1 (else 010110), bits 11:1 = 00000110100, and bit 0 = 1.
- R8: The bypass stage captures 0 and delays `tdi` by one shift.
- R9: Test-Logic-Reset loads code 001. Capture-IR loads 001 into the instruction shifter, so the first three bits shifted out of Shift-IR are 1, 0, 0.
- R10: `tdo` changes only on the falling edge of `tck`. `tdo_en` is high only while the controller is in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst | input | 1 | Synchronous active-high test reset (used when `TRST_EN`=1) |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| ring_in | input | 71 | Parallel snapshot of the I/O ring |
| tdo | output | 1 | Serial test data out, updated on the falling edge |
| tdo_en | output | 1 | Output enable for `tdo` |
| cap_strobe | output | 1 | High while the I/O ring is being captured |
| hiz_force | output | 1 | Forces the memory output drivers to high impedance |
| reg_sel | output | 2 | Register in the scan path: 0 bypass, 1 identification, 2 boundary |

## Verification
All eight instruction codes are loaded in turn. Each one is followed by a 71-bit data scan with a fixed ring pattern and a different shift-in pattern. Comparing the scanned-out bits shows which register sits in the path: the ring pattern means the boundary register, the identification word followed by the input data means the identification register, and a one-bit-delayed copy of the input means bypass. Directed sequences then cover the remaining behaviour. They check that the high-impedance force holds and is released across successive instructions, under a TMS-only reset and under `trst`. They show that shifted data under sample/preload is lost at the next capture. They confirm the instruction capture pattern, and they check that `tdo` does not move at the rising edge.

// File: rtl/mtap_pkg.sv
package mtap_pkg;
  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR,
    ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
  } tap_st_e;

  typedef enum logic [1:0] {SEL_BYP = 2'd0, SEL_ID = 2'd1, SEL_BSR = 2'd2} sel_e;

  localparam logic [IR_W-1:0] OP_CAPZ   = 3'b000;
  localparam logic [IR_W-1:0] OP_IDENT  = 3'b001;
  localparam logic [IR_W-1:0] OP_SNAPZ  = 3'b010;
  localparam logic [IR_W-1:0] OP_SNAP   = 3'b100;
  localparam logic [IR_W-1:0] OP_PASS   = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPVAL = 3'b001;

  function automatic sel_e sel_of(input logic [IR_W-1:0] op);
    case (op)
      OP_CAPZ, OP_SNAPZ, OP_SNAP: sel_of = SEL_BSR;
      OP_IDENT:                   sel_of = SEL_ID;
      default:                    sel_of = SEL_BYP;
    endcase
  endfunction

  function automatic logic hiz_of(input logic [IR_W-1:0] op);
    hiz_of = (op == OP_CAPZ) || (op == OP_SNAPZ);
  endfunction

  function automatic logic cap_of(input logic [IR_W-1:0] op);
    cap_of = (op == OP_CAPZ) || (op == OP_SNAPZ) || (op == OP_SNAP);
  endfunction
endpackage

// File: rtl/mtap_fsm.sv
module mtap_fsm
  import mtap_pkg::*;
(
  input  logic    tck,
  input  logic    rst,
  input  logic    tms,
  output tap_st_e state
);
  tap_st_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state <= ST_TLR;
    else     state <= nxt;
  end
endmodule

// File: rtl/mtap_ir.sv
module mtap_ir
  import mtap_pkg::*;
(
  input  logic            tck,
  input  tap_st_e         state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir,
  output logic            ir_sout,
  output logic            hiz_force
);
  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck) begin
    if (state == ST_CAP_IR)     ir_sh <= IR_CAPVAL;
    else if (state == ST_SH_IR) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
  end

  always_ff @(negedge tck) begin
    if (state == ST_TLR) begin
      ir        <= OP_IDENT;
      hiz_force <= 1'b0;
    end else if (state == ST_UPD_IR) begin
      ir        <= ir_sh;
      hiz_force <= hiz_of(ir_sh);
    end
  end

  assign ir_sout = ir_sh[0];
endmodule

// File: rtl/mtap_dr.sv
module mtap_dr
  import mtap_pkg::*;
#(
  parameter int BSR_W  = 71,
  parameter int ID_W   = 32,
  parameter bit WIDE36 = 1'b1
) (
  input  logic             tck,
  input  tap_st_e          state,
  input  logic             tdi,
  input  sel_e             sel,
  input  logic             cap_en,
  input  logic [BSR_W-1:0] ring_in,
  output logic             dr_sout
);
  localparam logic [5:0] WD_FIELD = WIDE36 ? 6'b100110 : 6'b010110;
  localparam logic [ID_W-1:0] ID_WORD =
    ID_W'({3'b001, 5'b01010, 6'b000000, WD_FIELD, 11'b00000110100, 1'b1});

  logic             byp;
  logic [ID_W-1:0]  id_sh;
  logic [BSR_W-1:0] bsr;

  always_ff @(posedge tck) begin
    if (state == ST_CAP_DR) begin
      case (sel)
        SEL_ID:  id_sh <= ID_WORD;
        SEL_BSR: if (cap_en) bsr <= ring_in;
        default: byp <= 1'b0;
      endcase
    end else if (state == ST_SH_DR) begin
      case (sel)
        SEL_ID:  id_sh <= {tdi, id_sh[ID_W-1:1]};
        SEL_BSR: bsr   <= {tdi, bsr[BSR_W-1:1]};
        default: byp   <= tdi;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_ID:  dr_sout = id_sh[0];
      SEL_BSR: dr_sout = bsr[0];
      default: dr_sout = byp;
    endcase
  end
endmodule

// File: rtl/mem_jtag_tap.sv
module mem_jtag_tap
  import mtap_pkg::*;
#(
  parameter int BSR_W   = 71,
  parameter int ID_W    = 32,
  parameter bit WIDE36  = 1'b1,
  parameter bit TRST_EN = 1'b1
) (
  input  logic             tck,
  input  logic             trst,
  input  logic             tms,
  input  logic             tdi,
  input  logic [BSR_W-1:0] ring_in,
  output logic             tdo,
  output logic             tdo_en,
  output logic             cap_strobe,
  output logic             hiz_force,
  output logic [1:0]       reg_sel
);
  tap_st_e         st_w;
  logic [IR_W-1:0] ir;
  logic            ir_sout, dr_sout, rst_i;
  sel_e            sel;

  generate
    if (TRST_EN) begin : g_trst
      assign rst_i = trst;
    end else begin : g_notrst
      assign rst_i = 1'b0;
    end
  endgenerate

  mtap_fsm u_fsm (.tck(tck), .rst(rst_i), .tms(tms), .state(st_w));

  mtap_ir u_ir (
    .tck(tck), .state(st_w), .tdi(tdi), .ir(ir), .ir_sout(ir_sout), .hiz_force(hiz_force)
  );

  assign sel        = sel_of(ir);
  assign reg_sel    = sel;
  assign cap_strobe = (st_w == ST_CAP_DR) && cap_of(ir);

  mtap_dr #(.BSR_W(BSR_W), .ID_W(ID_W), .WIDE36(WIDE36)) u_dr (
    .tck(tck), .state(st_w), .tdi(tdi), .sel(sel), .cap_en(cap_of(ir)),
    .ring_in(ring_in), .dr_sout(dr_sout)
  );

  always_ff @(negedge tck) begin
    tdo_en <= (st_w == ST_SH_DR) || (st_w == ST_SH_IR);
    tdo    <= (st_w == ST_SH_IR) ? ir_sout : dr_sout;
  end
endmodule

// File: rtl/mtap_chk.sv
module mtap_chk
  import mtap_pkg::*;
(
  input logic       tck,
  input logic       trst,
  input tap_st_e    st,
  input logic       tdo_en,
  input logic       cap_strobe,
  input logic       hiz_force,
  input logic [1:0] reg_sel
);
  AST_TDO_EN_SHIFT: assert property (@(posedge tck) disable iff (trst)
    tdo_en == (st == ST_SH_DR || st == ST_SH_IR)); // R10

  AST_HIZ_TLR_CLEAR: assert property (@(posedge tck) disable iff (trst)
    (st == ST_TLR) |-> !hiz_force); // R4

  AST_HIZ_ONLY_AT_UPDATE: assert property (@(posedge tck) disable iff (trst)
    !$stable(hiz_force) |-> (st == ST_UPD_IR || st == ST_TLR)); // R4

  AST_CAP_IN_CAPDR: assert property (@(posedge tck) disable iff (trst)
    cap_strobe |-> (st == ST_CAP_DR)); // R5

  AST_HIZ_WITH_BSR: assert property (@(posedge tck) disable iff (trst)
    hiz_force |-> (reg_sel == 2'd2)); // R2

  AST_TLR_IDENT: assert property (@(posedge tck) disable iff (trst)
    (st == ST_TLR) |-> (reg_sel == 2'd1)); // R9
endmodule

bind mem_jtag_tap mtap_chk u_chk (
  .tck(tck), .trst(trst), .st(st_w), .tdo_en(tdo_en),
  .cap_strobe(cap_strobe), .hiz_force(hiz_force), .reg_sel(reg_sel)
);

// File: tb/sim_mem_jtag_tap.sv
`timescale 1ns/1ps
module sim_mem_jtag_tap;
  localparam int BW = 71;
  localparam logic [31:0] ID_EXP =
    {3'b001, 5'b01010, 6'b000000, 6'b100110, 11'b00000110100, 1'b1};
  // {code[2:0], reg_sel[1:0], hiz, cap}
  localparam logic [6:0] VEC [8] = '{
    {3'b000, 2'd2, 1'b1, 1'b1}, {3'b001, 2'd1, 1'b0, 1'b0},
    {3'b010, 2'd2, 1'b1, 1'b1}, {3'b011, 2'd0, 1'b0, 1'b0},
    {3'b100, 2'd2, 1'b0, 1'b1}, {3'b101, 2'd0, 1'b0, 1'b0},
    {3'b110, 2'd0, 1'b0, 1'b0}, {3'b111, 2'd0, 1'b0, 1'b0}
  };
  localparam logic [BW-1:0] RING_A = {7'h5A, 64'hC3A5_0F1E_9B27_4D86};
  localparam logic [BW-1:0] RING_B = {7'h27, 64'h0123_4567_89AB_CDEF};
  localparam logic [BW-1:0] DIN_A  = {7'h33, 64'hF0F0_1234_AAAA_5A5B};

  logic tck = 1'b0, trst = 1'b1, tms = 1'b1, tdi = 1'b0;
  logic [BW-1:0] ring_in = RING_A;
  logic tdo, tdo_en, cap_strobe, hiz_force;
  logic [1:0] reg_sel;
  int n_run = 0, n_fail = 0;
  logic cap_seen;

  always #2 tck = ~tck;

  mem_jtag_tap u0 (
    .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .ring_in(ring_in), .tdo(tdo),
    .tdo_en(tdo_en), .cap_strobe(cap_strobe), .hiz_force(hiz_force), .reg_sel(reg_sel)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic load_ir(input logic [2:0] op, output logic [2:0] capt);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      capt[i] = tdo;
      step(i == 2, op[i]);
    end
    step(1, 0);
  endtask

  task automatic scan_dr(input int n, input logic [BW-1:0] din, output logic [BW-1:0] dout);
    step(1, 0); step(0, 0);
    cap_seen = cap_strobe;
    step(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] capt;
    logic [BW-1:0] dout, exp;
    repeat (3) @(negedge tck);
    #1;
    trst = 1'b0;
    chk("R9 reset reg_sel", 128'(reg_sel), 128'd1);
    chk("R4 reset hiz", 128'(hiz_force), 128'd0);
    chk("R10 reset tdo_en", 128'(tdo_en), 128'd0);
    step(0, 0);

    for (int v = 0; v < 8; v++) begin
      logic [2:0] op;
      op = VEC[v][6:4];
      load_ir(op, capt);
      chk($sformatf("R2 R3 reg_sel op=%0d", op), 128'(reg_sel), 128'(VEC[v][3:2]));
      chk($sformatf("R4 R6 hiz op=%0d", op), 128'(hiz_force), 128'(VEC[v][1]));
      step(0, 0);
      scan_dr(BW, DIN_A, dout);
      chk($sformatf("R5 cap_strobe op=%0d", op), 128'(cap_seen), 128'(VEC[v][0]));
      case (VEC[v][3:2])
        2'd2: exp = RING_A;
        2'd1: exp = {DIN_A[BW-33:0], ID_EXP};
        default: exp = {DIN_A[BW-2:0], 1'b0};
      endcase
      chk($sformatf("R5 R7 R8 scan-out op=%0d", op), 128'(dout), 128'(exp));
    end

    load_ir(3'b111, capt);
    chk("R9 capture-IR pattern 1,0,0", 128'(capt), 128'd1);
    step(0, 0);

    load_ir(3'b000, capt); step(0, 0);
    scan_dr(BW, DIN_A, dout);
    chk("R4 hiz held across scan", 128'(hiz_force), 128'd1);
    load_ir(3'b010, capt); step(0, 0);
    chk("R4 hiz under second forcing op", 128'(hiz_force), 128'd1);
    load_ir(3'b100, capt); step(0, 0);
    chk("R6 hiz released by sample op", 128'(hiz_force), 128'd0);
    load_ir(3'b000, capt); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    chk("R1 R4 TMS reset releases hiz", 128'(hiz_force), 128'd0);
    chk("R1 R9 TMS reset loads ident", 128'(reg_sel), 128'd1);
    step(0, 0);

    load_ir(3'b100, capt); step(0, 0);
    scan_dr(BW, DIN_A, dout);
    ring_in = RING_B;
    scan_dr(BW, ~DIN_A, dout);
    chk("R6 shifted data replaced by new capture", 128'(dout), 128'(RING_B));

    ring_in = RING_A;
    step(1, 0); step(0, 0); step(0, 0);
    chk("R10 tdo_en in Shift-DR", 128'(tdo_en), 128'd1);
    chk("R5 first bit", 128'(tdo), 128'(RING_A[0]));
    tms = 0; tdi = 0;
    @(posedge tck); #1;
    chk("R10 tdo held at rising edge", 128'(tdo), 128'(RING_A[0]));
    @(negedge tck); #1;
    chk("R10 tdo moves at falling edge", 128'(tdo), 128'(RING_A[1]));
    step(1, 0);
    chk("R10 tdo_en off in Exit1-DR", 128'(tdo_en), 128'd0);
    step(1, 0); step(0, 0);

    load_ir(3'b010, capt); step(0, 0);
    trst = 1'b1;
    step(0, 0);
    trst = 1'b0;
    chk("R1 R4 trst releases hiz", 128'(hiz_force), 128'd0);
    chk("R1 R9 trst loads ident", 128'(reg_sel), 128'd1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule